// File: doc/BRIEF.md
# Daisy-Chain Converter Readout Controller

This block is the host side of a chain of N serial sampling converters. The converters share one conversion-start line (`cnv`) and one serial clock (`sck`). Each device's serial input is fed from the serial output of its upstream neighbour. The serial input of the first device is tied to 0. Only the output of the last device reaches the host, on `sdi`.

A start request raises `cnv` while `sck` is low, which puts the devices into chain mode. The controller then waits a programmed number of clock cycles for the conversion. After that it produces exactly 18×N serial clock periods and samples `sdi` on every falling edge of `sck`. Each 18-bit result is presented on a parallel output with a one-cycle valid strobe and a device index. The device nearest the host comes first, with index 0, and the index rises toward the start of the chain. A one-cycle done pulse follows the last word, and `cnv` drops on the next cycle.

The conversion wait and the `sck` half period are configuration inputs. Both are captured when a frame starts, so a frame always runs on the values it started with. The chain length is a parameter.

Top module: `chain_rd_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `cnv`, `sck`, `word_vld` and `done` are all 0.
- R2: A `start` seen high at a clock edge while idle raises `cnv` in the next cycle, and `sck` is 0 in that cycle.
- R3: Let C = max(1, `conv_cycles`) and H = max(1, `sck_half`), both taken at the accepted start. Counting the first cycle with `cnv` high as cycle 0, the first cycle with `sck` high is cycle C+H, and `sck` stays low before it.
- R4: During a frame, `sck` has exactly 18×N_DEV rising edges. Every high phase lasts H cycles, and every low phase between two high phases lasts H cycles. `sck` is 0 whenever `cnv` is 0.
- R5: `sdi` is sampled at the clock edge where `sck` falls. The bit present on `sdi` before the first `sck` edge is the first bit taken.
- R6: The serial stream is split into N_DEV words of 18 bits, each assembled MSB first. Word k (k = 0 is the first received, coming from the device nearest the host) appears on `word_data` with `word_idx` = k and `word_vld` high for exactly one cycle. The words appear in rising k order.
- R7: `done` is high for exactly one cycle per frame, in the cycle right after the last word's `word_vld`. `cnv` is 0 from the cycle after `done`.
- R8: A `start` that arrives while `cnv` is high is ignored. No further frame starts after `done` unless `start` is asserted again.
- R9: Changes to `conv_cycles` or `sck_half` during a frame have no effect on that frame's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request one conversion-and-readout frame |
| conv_cycles | input | CONV_W | Conversion wait in clock cycles (0 treated as 1) |
| sck_half | input | DIV_W | Serial clock half period in clock cycles (0 treated as 1) |
| sdi | input | 1 | Serial data from the last device in the chain |
| cnv | output | 1 | Conversion start line to all devices, held high for the whole frame |
| sck | output | 1 | Serial clock to all devices, idles low |
| word_data | output | 18 | Received result word |
| word_vld | output | 1 | One-cycle strobe for `word_data` |
| word_idx | output | IDX_W | Chain position of the word (0 = nearest the host) |
| done | output | 1 | One-cycle pulse after the final word |

## Verification
The bench builds the controller with N_DEV = 3, CONV_W = 8 and DIV_W = 4. This gives 54 serial clocks per frame and word indices that cross a bit boundary of the index counter.

The 4-bit half-period input reaches both the fastest serial clock (H = 1, a falling-edge capture every second cycle) and the slowest one (H = 15). The zero-means-one rule is reached on both configuration inputs. The 8-bit wait reaches its maximum of 255 cycles.

A behavioural chain of three devices shifts on the falling `sck` edge. Each frame carries random or patterned words, and the bench also issues a start request and new configuration values in the middle of each frame.

// File: rtl/chain_rd_pkg.sv
// Shared constants and types for the daisy-chain readout controller.
// Assumes every converter in the chain returns a fixed 18-bit result.
package chain_rd_pkg;
    localparam int WORD_BITS = 18;

    typedef enum logic [2:0] {
        ST_IDLE,   // no frame, cnv low
        ST_CONV,   // cnv high, waiting for conversion
        ST_SHIFT,  // serial clock running
        ST_TAIL,   // last word strobe cycle
        ST_DONE    // done pulse, cnv still high
    } seq_state_t;
endpackage

// File: rtl/chain_rd_sck.sv
// Serial clock generator. While run is high it toggles sck every 'half'
// clock cycles, starting from low. It flags the cycle whose edge turns sck
// from high to low. Assumes 'half' is nonzero and stable while run is high.
module chain_rd_sck #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             sck,
    output logic             fall_stb
);
    logic [DIV_W-1:0] hc;
    logic             sck_q;
    logic             wrap;

    // Terminal count of the half-period counter.
    assign wrap     = (hc == half - DIV_W'(1));
    // Falling edge happens at the next clock edge.
    assign fall_stb = run && sck_q && wrap;
    assign sck      = sck_q;

    // Half-period counter and sck toggle flop.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            hc    <= '0;
            sck_q <= 1'b0;
        end else if (wrap) begin
            hc    <= '0;
            sck_q <= ~sck_q;
        end else begin
            hc <= hc + DIV_W'(1);
        end
    end

    // R4
    sck_half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (hc < half));

    // R4
    sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sck_q);
endmodule

// File: rtl/chain_rd_seq.sv
// Frame sequencer. It accepts a start while idle and latches the
// configuration, mapping 0 to 1. It holds the conversion wait, runs the
// serial clock for 18*N_DEV falling edges, then steps through the final
// word cycle and the done cycle. Assumes fall_stb comes from the clock
// generator that this sequencer enables.
module chain_rd_seq
    import chain_rd_pkg::*;
#(
    parameter int N_DEV  = 3,
    parameter int CONV_W = 8,
    parameter int DIV_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CONV_W-1:0] conv_cycles,
    input  logic [DIV_W-1:0]  sck_half,
    input  logic              fall_stb,
    output logic              cnv,
    output logic              shift_run,
    output logic              frame_start,
    output logic              done,
    output logic [DIV_W-1:0]  half_q
);
    localparam int TOTAL_BITS = WORD_BITS * N_DEV;
    localparam int CNT_W      = $clog2(TOTAL_BITS + 1);

    seq_state_t        state;
    logic [CONV_W-1:0] conv_cnt;
    logic [CNT_W-1:0]  fall_cnt;

    // Decode outputs from the state register.
    assign frame_start = (state == ST_IDLE) && start;
    assign cnv         = (state != ST_IDLE);
    assign shift_run   = (state == ST_SHIFT);
    assign done        = (state == ST_DONE);

    // State transitions, conversion countdown and falling-edge count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            conv_cnt <= '0;
            fall_cnt <= '0;
            half_q   <= DIV_W'(1);
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    conv_cnt <= (conv_cycles == '0) ? CONV_W'(1) : conv_cycles;
                    half_q   <= (sck_half == '0) ? DIV_W'(1) : sck_half;
                    fall_cnt <= '0;
                    state    <= ST_CONV;
                end
                ST_CONV: begin
                    if (conv_cnt <= CONV_W'(1)) state <= ST_SHIFT;
                    else conv_cnt <= conv_cnt - CONV_W'(1);
                end
                ST_SHIFT: if (fall_stb) begin
                    if (fall_cnt == CNT_W'(TOTAL_BITS - 1)) state <= ST_TAIL;
                    else fall_cnt <= fall_cnt + CNT_W'(1);
                end
                ST_TAIL: state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8
    start_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_CONV) |-> $past(state == ST_IDLE));

    // R3
    shift_after_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_SHIFT) |-> $past(state == ST_CONV));

    // R4
    fall_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall_cnt <= CNT_W'(TOTAL_BITS - 1));
endmodule

// File: rtl/chain_rd_deser.sv
// Word assembler. It shifts one sdi bit in on each capture strobe, MSB
// first. Every 18 bits it presents the word with a one-cycle valid and a
// running device index. Assumes clear precedes each frame and that
// captures are at least two cycles apart.
module chain_rd_deser
    import chain_rd_pkg::*;
#(
    parameter int N_DEV = 3,
    parameter int IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 cap,
    input  logic                 sdi,
    output logic [WORD_BITS-1:0] word_data,
    output logic                 word_vld,
    output logic [IDX_W-1:0]     word_idx
);
    localparam int BIT_W = $clog2(WORD_BITS);

    logic [WORD_BITS-1:0] sh;
    logic [BIT_W-1:0]     bit_cnt;
    logic [IDX_W-1:0]     idx_cnt;
    logic [WORD_BITS-1:0] next_sh;

    // Shift register contents after taking the current bit.
    assign next_sh = {sh[WORD_BITS-2:0], sdi};

    // Bit capture, word completion and index counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh        <= '0;
            bit_cnt   <= '0;
            idx_cnt   <= '0;
            word_data <= '0;
            word_vld  <= 1'b0;
            word_idx  <= '0;
        end else begin
            word_vld <= 1'b0;
            if (clear) begin
                bit_cnt <= '0;
                idx_cnt <= '0;
            end else if (cap) begin
                sh <= next_sh;
                if (bit_cnt == BIT_W'(WORD_BITS - 1)) begin
                    word_data <= next_sh;
                    word_vld  <= 1'b1;
                    word_idx  <= idx_cnt;
                    idx_cnt   <= idx_cnt + IDX_W'(1);
                    bit_cnt   <= '0;
                end else begin
                    bit_cnt <= bit_cnt + BIT_W'(1);
                end
            end
        end
    end

    // R6
    word_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |=> !word_vld);

    // R6
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> (int'(word_idx) < N_DEV));
endmodule

// File: rtl/chain_rd_ctrl.sv
// Top of the daisy-chain readout controller. It ties the sequencer, the
// serial clock generator and the word assembler together. Assumes the
// converters shift on the falling sck edge and that the first result bit
// is on sdi once the programmed conversion wait has elapsed.
module chain_rd_ctrl
    import chain_rd_pkg::*;
#(
    parameter int N_DEV  = 3,
    parameter int CONV_W = 8,
    parameter int DIV_W  = 4,
    localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CONV_W-1:0]    conv_cycles,
    input  logic [DIV_W-1:0]     sck_half,
    input  logic                 sdi,
    output logic                 cnv,
    output logic                 sck,
    output logic [WORD_BITS-1:0] word_data,
    output logic                 word_vld,
    output logic [IDX_W-1:0]     word_idx,
    output logic                 done
);
    logic             shift_run;
    logic             frame_start;
    logic             fall_stb;
    logic [DIV_W-1:0] half_q;

    chain_rd_seq #(.N_DEV(N_DEV), .CONV_W(CONV_W), .DIV_W(DIV_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .conv_cycles (conv_cycles),
        .sck_half    (sck_half),
        .fall_stb    (fall_stb),
        .cnv         (cnv),
        .shift_run   (shift_run),
        .frame_start (frame_start),
        .done        (done),
        .half_q      (half_q)
    );

    chain_rd_sck #(.DIV_W(DIV_W)) u_sck (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (shift_run),
        .half     (half_q),
        .sck      (sck),
        .fall_stb (fall_stb)
    );

    chain_rd_deser #(.N_DEV(N_DEV), .IDX_W(IDX_W)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (frame_start),
        .cap       (fall_stb),
        .sdi       (sdi),
        .word_data (word_data),
        .word_vld  (word_vld),
        .word_idx  (word_idx)
    );

    // R2
    cnv_rise_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cnv) |-> !sck);

    // R4
    sck_within_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnv |-> !sck);

    // R7
    done_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(word_vld));

    // R7
    cnv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !cnv);
endmodule

// File: tb/tb_chain_rd_ctrl.sv
module tb_chain_rd_ctrl;
    localparam int N_DEV  = 3;
    localparam int CONV_W = 8;
    localparam int DIV_W  = 4;
    localparam int WB     = 18;
    localparam int TOTAL  = WB * N_DEV;
    localparam int IDX_W  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [CONV_W-1:0] conv_cycles = '0;
    logic [DIV_W-1:0]  sck_half = '0;
    logic              sdi;
    logic              cnv, sck, word_vld, done;
    logic [WB-1:0]     word_data;
    logic [IDX_W-1:0]  word_idx;

    int n_chk = 0;
    int n_fail = 0;

    // Device chain model state
    logic [TOTAL-1:0] chain = '0;
    logic [TOTAL-1:0] frame_bits = '0;
    logic             loaded = 1'b0;
    logic             sck_d = 1'b0;
    int               mcnt = 0;
    int               cur_c = 1;
    logic [WB-1:0]    dw [N_DEV];

    always #2 clk = ~clk;

    chain_rd_ctrl #(.N_DEV(N_DEV), .CONV_W(CONV_W), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .conv_cycles(conv_cycles),
        .sck_half(sck_half), .sdi(sdi), .cnv(cnv), .sck(sck),
        .word_data(word_data), .word_vld(word_vld), .word_idx(word_idx),
        .done(done)
    );

    // Chain model: data appears after the conversion wait and shifts on
    // each falling sck; the first device receives 0.
    assign sdi = chain[TOTAL-1];
    always @(posedge clk) begin
        sck_d <= sck;
        if (!cnv) begin
            chain  <= '0;
            loaded <= 1'b0;
            mcnt   <= 0;
        end else if (!loaded) begin
            if (mcnt == cur_c - 1) begin
                chain  <= frame_bits;
                loaded <= 1'b1;
            end else begin
                mcnt <= mcnt + 1;
            end
        end else if (sck_d && !sck) begin
            chain <= {chain[TOTAL-2:0], 1'b0};
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic run_frame(input int c, input int h, input int pat);
        int ce, he, t, first_rise, rises, bad_len, run_len, got;
        int last_word_t, done_t, done_cnt, fall_t, stray;
        logic prev;
        ce = eff(c);
        he = eff(h);
        for (int k = 0; k < N_DEV; k++) begin
            case (pat)
                1: dw[k] = '1;
                2: dw[k] = '0;
                3: dw[k] = (k % 2 == 0) ? 18'h2AAAA : 18'h15555;
                default: dw[k] = WB'($urandom);
            endcase
            frame_bits[TOTAL-1-WB*k -: WB] = dw[k];
        end
        cur_c = ce;
        @(negedge clk);
        conv_cycles = CONV_W'(c);
        sck_half    = DIV_W'(h);
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(cnv == 1'b1 && sck == 1'b0, "R2", "cnv/sck after start",
              {cnv, sck}, 2);
        first_rise = -1; rises = 0; bad_len = 0; run_len = 1; got = 0;
        last_word_t = -1; done_t = -1; done_cnt = 0; fall_t = -1;
        prev = sck;
        t = 0;
        while (t < 20000) begin
            @(negedge clk);
            t++;
            if (t == 3) begin
                start = 1'b1;
                conv_cycles = CONV_W'($urandom);
                sck_half = DIV_W'($urandom);
            end
            if (t == 4) start = 1'b0;
            if (!cnv) begin
                fall_t = t;
                break;
            end
            if (sck != prev) begin
                if (prev && run_len != he) bad_len++;
                if (!prev && rises > 0 && run_len != he) bad_len++;
                if (sck) begin
                    rises++;
                    if (first_rise < 0) first_rise = t;
                end
                run_len = 1;
            end else begin
                run_len++;
            end
            prev = sck;
            if (word_vld) begin
                if (got < N_DEV) begin
                    // R5: bits taken on falling sck, MSB first, first bit pre-edge
                    check(word_data == dw[got], "R5", "word data",
                          word_data, dw[got]);
                    check(int'(word_idx) == got, "R6", "word index",
                          word_idx, got);
                end
                got++;
                last_word_t = t;
            end
            if (done) begin
                done_cnt++;
                done_t = t;
            end
        end
        check(first_rise == ce + he, "R3", "first sck rise cycle",
              first_rise, ce + he);
        check(rises == TOTAL, "R4", "sck rising edges", rises, TOTAL);
        check(bad_len == 0, "R9", "sck phase lengths off (R4)", bad_len, 0);
        check(got == N_DEV, "R6", "words per frame", got, N_DEV);
        check(done_cnt == 1 && done_t == last_word_t + 1, "R7", "done cycle",
              done_t, last_word_t + 1);
        check(fall_t == done_t + 1, "R7", "cnv fall cycle", fall_t, done_t + 1);
        stray = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (cnv || sck || word_vld || done) stray++;
        end
        check(stray == 0, "R8", "activity after frame", stray, 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        check(!cnv && !sck && !word_vld && !done, "R1", "outputs in reset",
              {cnv, sck, word_vld, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!cnv && !sck && !word_vld && !done, "R1", "outputs after reset",
              {cnv, sck, word_vld, done}, 0);
        // Directed corners
        run_frame(0, 0, 1);
        run_frame(1, 1, 2);
        run_frame(255, 15, 3);
        run_frame(2, 0, 0);
        run_frame(0, 7, 0);
        // Constrained random
        for (int f = 0; f < 8; f++) begin
            run_frame(1 + int'($urandom % 40), 1 + int'($urandom % 4), 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule